// File: doc/BRIEF.md
# Two-Wire EEPROM Byte-Write Slave

This block is the slave side of a two-wire serial bus for a small byte-wide store. The store is modelled as on-chip registers. The block samples the bus clock and data lines with the system clock and detects START and STOP conditions. It checks the control byte against its device code. It then takes a word address and one or more data bytes, and acknowledges each accepted byte by pulling the data line low during the ninth bus clock.

No location changes while the bytes arrive. The last complete data byte is written only when the master sends STOP. The write then starts an internally timed cycle, and `busy` is high for that cycle. While `busy` is high, every control byte is refused. A master can therefore poll the block with control bytes until one is acknowledged.

A STOP that comes too early cancels the command. A low-supply input also blocks the write. A combinational lookup port and the current address pointer let the surrounding logic see the stored contents.

Top module: `twoWireStore`

## Requirements
- R1: After reset, every location holds 8'hFF, `busy` is low, `sdaPullLow` is low and `ptr` is 0.
- R2: An accepted byte is acknowledged with `sdaPullLow` high during the ninth SCL high phase. Accepted bytes are the control byte, the word address and each data byte. `sdaPullLow` only rises while the synchronized SCL is low.
- R3: The control byte is sent MSB first. Its bits 7:4 must equal `DEV_CODE` (default 4'b1010) and its bit 0 must be 0 (write); bits 3:1 are ignored. Any other control byte is not acknowledged, and the bytes that follow it are ignored until the next START.
- R4: Only bits 3:0 of the word address select a location; bits 7:4 are ignored.
- R5: No location changes before a STOP that follows a complete control, address and data sequence. That STOP writes the data byte to the addressed location.
- R6: `busy` goes high on the clock after the writing STOP and stays high for exactly `WRITE_CYCLES` clocks. While it is high, no control byte is acknowledged. After it falls, control bytes are acknowledged again.
- R7: After a write, `ptr` still holds the location just written; it is not incremented.
- R8: A STOP during the control byte or the address byte, or before the first data byte is complete, aborts the command. Nothing is written and `busy` stays low.
- R9: A further complete data byte replaces the buffered one, and the last complete byte is the one written. A STOP partway through a later data byte aborts the command, and nothing is written.
- R10: If `lowSupply` is high at the writing STOP, nothing is written and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| lowSupply | input | 1 | High blocks the commit of a write |
| rdAddr | input | 4 | Lookup address into the store |
| sdaPullLow | output | 1 | High pulls the data line low (acknowledge) |
| busy | output | 1 | High during the timed internal write cycle |
| ptr | output | 4 | Current address pointer |
| rdData | output | 8 | Contents of the location at `rdAddr` |

## Verification
The bench goes after the moments where the byte buffer and the STOP meet.

- **STOP right after a data acknowledge.** The first SCL rise of the STOP looks like a new data bit. A design that treated that rise as an overrun would drop every write.
- **Second full data byte.** A design that kept the first byte would store stale data.
- **Partial second byte.** A design that did not mark the buffer as discarded would write it anyway.
- **Polling during the write cycle.** A design that ignored `busy` at the control byte would acknowledge polls too early.
- **Address upper bits, don't-care bits and device code.** A design that decoded the wrong bits would write to the wrong location or accept a foreign device code.
- **Low-supply inhibit.** A design that did not gate the commit would change the store anyway.

// File: rtl/twsPkg.sv
package twsPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ACK_CTRL,
    PH_ADDR,
    PH_ACK_ADDR,
    PH_DATA,
    PH_ACK_DATA
  } phase_t;

  // Bus events, each one system clock wide
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic loadData;
    logic dropData;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/twsBusSync.sv
module twsBusSync
  import twsPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output logic    sclSync,
  output logic    sdaSync,
  output busEvt_t evt
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    evt.start   = sclSync && sclPrev && sdaPrev && !sdaSync;
    evt.stop    = sclSync && sclPrev && !sdaPrev && sdaSync;
    evt.sclRise = sclSync && !sclPrev;
    evt.sclFall = !sclSync && sclPrev;
  end

endmodule

// File: rtl/twsCtrl.sv
module twsCtrl
  import twsPkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    ctrlOk,
  input  logic    busy,
  output logic    ackOn,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  phase_t phase;
  logic [CNT_W-1:0] bitCnt;
  logic receiving;
  logic byteDone;
  logic accept;

  assign receiving = (phase == PH_CTRL) || (phase == PH_ADDR) || (phase == PH_DATA);
  assign byteDone  = receiving && evt.sclFall && (bitCnt == FULL);

  always_comb begin
    accept = 1'b1;
    if (phase == PH_CTRL) accept = ctrlOk && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (evt.start) begin
      phase  <= PH_CTRL;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (evt.stop) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else begin
      unique case (phase)
        PH_CTRL, PH_ADDR, PH_DATA: begin
          if (evt.sclRise && bitCnt != FULL) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            if (accept) begin
              ackOn <= 1'b1;
              phase <= (phase == PH_CTRL) ? PH_ACK_CTRL :
                       (phase == PH_ADDR) ? PH_ACK_ADDR : PH_ACK_DATA;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_ACK_CTRL, PH_ACK_ADDR, PH_ACK_DATA: begin
          if (evt.sclFall) begin
            ackOn  <= 1'b0;
            bitCnt <= '0;
            phase  <= (phase == PH_ACK_CTRL) ? PH_ADDR : PH_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.shiftIn  = receiving && evt.sclRise && (bitCnt != FULL) && !evt.start && !evt.stop;
    stb.loadPtr  = byteDone && (phase == PH_ADDR);
    stb.loadData = byteDone && (phase == PH_DATA);
    // a new byte is confirmed only when its first bit's clock falls
    stb.dropData = evt.start ||
                   ((phase == PH_DATA) && evt.sclFall && (bitCnt == CNT_W'(1)));
    // the first SCL rise of a STOP is seen as one bit, so allow up to one
    stb.commit   = evt.stop && (phase == PH_DATA) && (bitCnt <= CNT_W'(1));
  end

endmodule

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int          ADDR_BITS    = 4,
  parameter int          DATA_W       = 8,
  parameter logic [3:0]  DEV_CODE     = 4'b1010,
  parameter int          WRITE_CYCLES = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic                 sdaSync,
  input  logic                 lowSupply,
  input  logic [ADDR_BITS-1:0] rdAddr,
  output logic                 ctrlOk,
  output logic                 busy,
  output logic [ADDR_BITS-1:0] ptr,
  output logic [DATA_W-1:0]    rdData
);

  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataBuf;
  logic              dataValid;
  logic [TMR_W-1:0]  timer;
  logic              wrEn;
  logic [DATA_W-1:0] mem [DEPTH];

  assign ctrlOk = (shiftReg[DATA_W-1 -: 4] == DEV_CODE) && !shiftReg[0];
  assign wrEn   = stb.commit && dataValid && !lowSupply;
  assign busy   = (timer != '0);
  assign rdData = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      dataBuf   <= '0;
      dataValid <= 1'b0;
      ptr       <= '0;
    end else begin
      if (stb.shiftIn) shiftReg <= {shiftReg[DATA_W-2:0], sdaSync};
      if (stb.loadPtr) ptr <= shiftReg[ADDR_BITS-1:0];
      if (stb.loadData) begin
        dataBuf   <= shiftReg;
        dataValid <= 1'b1;
      end else if (stb.dropData || stb.commit) begin
        dataValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (wrEn) begin
      timer <= TMR_W'(WRITE_CYCLES);
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
    end else if (wrEn) begin
      mem[ptr] <= dataBuf;
    end
  end

endmodule

// File: rtl/twoWireStore.sv
module twoWireStore
  import twsPkg::*;
#(
  parameter logic [3:0] DEV_CODE     = 4'b1010,
  parameter int         WRITE_CYCLES = 200,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       lowSupply,
  input  logic [3:0] rdAddr,
  output logic       sdaPullLow,
  output logic       busy,
  output logic [3:0] ptr,
  output logic [7:0] rdData
);

  busEvt_t evt;
  strobe_t stb;
  logic sclSync;
  logic sdaSync;
  logic ctrlOk;

  twsBusSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .evt(evt)
  );

  twsCtrl #(.BYTE_BITS(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .ctrlOk(ctrlOk), .busy(busy),
    .ackOn(sdaPullLow), .stb(stb)
  );

  twsDatapath #(
    .ADDR_BITS(4), .DATA_W(8), .DEV_CODE(DEV_CODE), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaSync(sdaSync), .lowSupply(lowSupply),
    .rdAddr(rdAddr), .ctrlOk(ctrlOk), .busy(busy), .ptr(ptr), .rdData(rdData)
  );

endmodule

// File: rtl/twsChecker.sv
module twsChecker #(
  parameter int WRITE_CYCLES = 200
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclSync,
  input logic       sdaPullLow,
  input logic       busy,
  input logic       commitStb,
  input logic       loadPtrStb,
  input logic [3:0] ptr
);

  int busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (!busy) busyLen <= 0;
    else busyLen <= busyLen + 1;
  end

  // R2
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclSync);

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !$rose(sdaPullLow));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == WRITE_CYCLES));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadPtrStb |=> $stable(ptr));

  // R5
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !busy);

endmodule

bind twoWireStore twsChecker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaPullLow(sdaPullLow),
  .busy(busy), .commitStb(stb.commit), .loadPtrStb(stb.loadPtr), .ptr(ptr)
);

// File: tb/twoWireStore_tb.sv
module twoWireStore_tb;

  localparam int WC = 1500;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic lowSupply = 1'b0;
  logic [3:0] rdAddr = '0;
  logic sdaPullLow, busy;
  logic [3:0] ptr;
  logic [7:0] rdData;
  logic sdaLine;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  twoWireStore #(.WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .lowSupply(lowSupply),
    .rdAddr(rdAddr), .sdaPullLow(sdaPullLow), .busy(busy), .ptr(ptr), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(Q);
    sclM = 1'b1; waitQ(2 * Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    ack = sdaPullLow;
    waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic readMem(input logic [3:0] a, output logic [7:0] d);
    rdAddr = a;
    waitQ(1);
    d = rdData;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * WC && busy; i++) waitQ(1);
  endtask

  task automatic testReset();
    logic [7:0] d;
    readMem(4'd0, d);  check(d == 8'hFF, "R1", "mem[0] after reset", d, 8'hFF);
    readMem(4'd15, d); check(d == 8'hFF, "R1", "mem[15] after reset", d, 8'hFF);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(sdaPullLow == 1'b0, "R1", "sda drive after reset", sdaPullLow, 0);
    check(ptr == 4'd0, "R1", "ptr after reset", ptr, 0);
  endtask

  task automatic testByteWrite();
    logic ack;
    logic [7:0] d;
    int len;
    busStart();
    sendByte(8'hA0, ack); check(ack, "R2", "control ack", ack, 1);
    sendByte(8'h35, ack); check(ack, "R2", "address ack", ack, 1);
    sendByte(8'hA7, ack); check(ack, "R2", "data ack", ack, 1);
    readMem(4'd5, d); check(d == 8'hFF, "R5", "mem[5] before stop", d, 8'hFF);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1;
    len = 0;
    for (int i = 0; i < 4 * WC; i++) begin
      waitQ(1);
      if (busy) len++;
      else if (len > 0) break;
    end
    check(len == WC, "R6", "busy length", len, WC);
    readMem(4'd5, d); check(d == 8'hA7, "R4", "mem[5] via address 0x35", d, 8'hA7);
    readMem(4'd3, d); check(d == 8'hFF, "R4", "mem[3] untouched", d, 8'hFF);
    check(ptr == 4'd5, "R7", "ptr after write", ptr, 5);
  endtask

  task automatic testPolling();
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h07, ack); sendByte(8'h5C, ack);
    busStop();
    check(busy == 1'b1, "R6", "busy right after stop", busy, 1);
    busStart();
    sendByte(8'hA0, ack); check(!ack, "R6", "poll during write cycle", ack, 0);
    busStop();
    waitIdle();
    busStart();
    sendByte(8'hA0, ack); check(ack, "R6", "poll after write cycle", ack, 1);
    busStop();
    readMem(4'd7, d); check(d == 8'h5C, "R5", "mem[7] after write", d, 8'h5C);
    check(ptr == 4'd7, "R7", "ptr after write to 7", ptr, 7);
  endtask

  task automatic testControl();
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte(8'hB0, ack); check(!ack, "R3", "wrong device code", ack, 0);
    sendByte(8'h01, ack); check(!ack, "R3", "byte after refused control", ack, 0);
    busStop();
    busStart();
    sendByte(8'hA1, ack); check(!ack, "R3", "read bit set", ack, 0);
    busStop();
    busStart();
    sendByte(8'hAE, ack); check(ack, "R3", "don't-care bits set", ack, 1);
    sendByte(8'h0A, ack); sendByte(8'h99, ack);
    busStop();
    waitIdle();
    readMem(4'd10, d); check(d == 8'h99, "R3", "mem[10] after write", d, 8'h99);
  endtask

  task automatic testAbort();
    logic ack;
    logic [7:0] d;
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop(); waitQ(4);
    check(busy == 1'b0, "R8", "busy after stop in control", busy, 0);
    busStart();
    sendByte(8'hA0, ack); busStop(); waitQ(4);
    check(busy == 1'b0, "R8", "busy after stop past control", busy, 0);
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h04, ack); busStop(); waitQ(4);
    check(busy == 1'b0, "R8", "busy after stop past address", busy, 0);
    readMem(4'd4, d); check(d == 8'hFF, "R8", "mem[4] untouched", d, 8'hFF);
  endtask

  task automatic testOverrun();
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h02, ack);
    sendByte(8'h11, ack); sendByte(8'h22, ack);
    check(ack, "R9", "second data byte ack", ack, 1);
    busStop();
    waitIdle();
    readMem(4'd2, d); check(d == 8'h22, "R9", "mem[2] holds last byte", d, 8'h22);
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h03, ack); sendByte(8'h44, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop(); waitQ(4);
    check(busy == 1'b0, "R9", "busy after partial byte", busy, 0);
    readMem(4'd3, d); check(d == 8'hFF, "R9", "mem[3] untouched", d, 8'hFF);
  endtask

  task automatic testLowSupply();
    logic ack;
    logic [7:0] d;
    lowSupply = 1'b1;
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h09, ack); sendByte(8'h66, ack);
    busStop(); waitQ(4);
    check(busy == 1'b0, "R10", "busy with low supply", busy, 0);
    readMem(4'd9, d); check(d == 8'hFF, "R10", "mem[9] untouched", d, 8'hFF);
    lowSupply = 1'b0;
  endtask

  initial begin
    waitQ(5);
    rstN = 1'b1;
    waitQ(5);
    testReset();
    testByteWrite();
    testPolling();
    testControl();
    testAbort();
    testOverrun();
    testLowSupply();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule